// File: doc/BRIEF.md
# Clockless Request/Acknowledge Word Link

This block joins an initiator and a responder that share no timing reference other than a pair of request and acknowledge lines. The initiator takes one command word at a time (read or write, a word address and, for a write, a data word). It places the address, the direction and the write data on the bus. It then waits a programmable number of cycles so that responders can decode the address, and only then raises request. The responder holds a small word store. It acts on the request and answers through acknowledge, and the two sides then step back to idle in a strict four-phase order.

Both sides are modelled in one clock domain, but each side samples the other's control line only through its own two-flop synchronizer, so the crossing behaves as it would between unrelated clocks. On a write, a rising acknowledge means the word has been stored. On a read, a rising acknowledge means the read word is valid on the bus. The initiator then captures it and releases request. The responder holds the read word steady until it sees request fall.

Top module: `hs_link`

## Requirements
- R1: After reset, bus_req and bus_ack are low, cmd_ready is high, rsp_valid is low, and every word of the store reads as 0.
- R2: A command is accepted on a rising clock edge where cmd_valid and cmd_ready are both high (cmd_write 1 = write, 0 = read). The address and direction appear on bus_addr and bus_write right after that edge, and bus_req rises exactly SETTLE_CYC clock cycles later.
- R3: The responder raises bus_ack only while it is seeing bus_req high.
- R4: The initiator lowers bus_req only after it has observed bus_ack high.
- R5: The responder lowers bus_ack only after it has observed bus_req low, and this ends the transaction.
- R6: Sampled once per cycle, the pair (bus_req, bus_ack) either holds its value or takes the next step of the cycle 00, 10, 11, 01, 00. No other change occurs.
- R7: A write stores cmd_wdata at cmd_addr. A later read of that address returns it.
- R8: A read returns the stored word on rsp_rdata while rsp_valid is high. The responder's read word does not change while bus_ack stays high.
- R9: cmd_ready is low from acceptance until the transaction has finished. A cmd_valid pulse seen while cmd_ready is low is ignored and changes no stored word.
- R10: rsp_valid is a single-cycle pulse that goes high SETTLE_CYC+12 clock cycles after the accepting edge, once bus_ack has returned low.
- R11: bus_addr and bus_write do not change while bus_req or bus_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both modelled sides |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 4 | Word address |
| cmd_wdata | input | 8 | Write data |
| cmd_ready | output | 1 | Initiator idle and able to take a command |
| rsp_valid | output | 1 | One-cycle pulse when a transaction has finished |
| rsp_rdata | output | 8 | Word captured on the last read |
| bus_req | output | 1 | Request line, as driven by the initiator |
| bus_ack | output | 1 | Acknowledge line, as driven by the responder |
| bus_addr | output | 4 | Address lines, as driven by the initiator |
| bus_write | output | 1 | Direction line, as driven by the initiator |

## Verification
With the default SETTLE_CYC of 2, the accepting edge is counted as edge 0. Request rises after edge 2. Acknowledge rises after edge 5, request falls after edge 8 and acknowledge falls after edge 11. The completion pulse follows edge 14: each synchronizer adds two edges and each side's reaction adds one more. The bench drives on falling edges and samples on falling edges. It counts falling edges from the one on which it offered the command, so it expects request high first at count SETTLE_CYC+1 and rsp_valid at count SETTLE_CYC+13. Request/acknowledge legality is checked every falling edge by a monitor, independently of those counts.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int HS_ADDR_W = 4;
    localparam int HS_DATA_W = 8;
    localparam int HS_DEPTH  = 1 << HS_ADDR_W;

    typedef logic [HS_ADDR_W-1:0] hs_addr_t;
    typedef logic [HS_DATA_W-1:0] hs_data_t;

    // Command word held by the initiator for the whole transaction
    typedef struct packed {
        logic     write;
        hs_addr_t addr;
        hs_data_t wdata;
    } hs_cmd_t;

    typedef enum logic [1:0] {
        INI_IDLE,
        INI_SETTLE,
        INI_REQ,
        INI_RELEASE
    } ini_state_t;

    typedef enum logic {
        RSP_WAIT,
        RSP_HOLD
    } rsp_state_t;

    // Legal one-cycle step of the (req, ack) pair: hold or advance 00->10->11->01->00
    function automatic logic hs_step_ok(input logic pr, input logic pa,
                                        input logic cr, input logic ca);
        logic [1:0] p;
        logic [1:0] c;
        p = {pr, pa};
        c = {cr, ca};
        if (p == c) return 1'b1;
        case (p)
            2'b00:   return c == 2'b10;
            2'b10:   return c == 2'b11;
            2'b11:   return c == 2'b01;
            2'b01:   return c == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_initiator.sv
module hs_initiator
    import hs_pkg::*;
#(
    parameter int SETTLE_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  hs_cmd_t  cmd_in,
    output logic     cmd_ready,
    output logic     rsp_valid,
    output hs_data_t rsp_rdata,
    output logic     req,
    input  logic     ack_line,
    output hs_cmd_t  bus_cmd,
    input  hs_data_t bus_rdata
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    ini_state_t       state;
    logic [CNT_W-1:0] settle_cnt;
    hs_cmd_t          cmd_q;
    hs_data_t         rdata_q;
    logic             ack_seen;

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_line),
        .q   (ack_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= INI_IDLE;
            settle_cnt <= '0;
            cmd_q      <= '0;
            rdata_q    <= '0;
            req        <= 1'b0;
            rsp_valid  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                INI_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q      <= cmd_in;
                        settle_cnt <= '0;
                        state      <= INI_SETTLE;
                    end
                end
                INI_SETTLE: begin
                    if (settle_cnt == CNT_LAST) begin
                        req   <= 1'b1;
                        state <= INI_REQ;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                INI_REQ: begin
                    if (ack_seen) begin
                        if (!cmd_q.write) rdata_q <= bus_rdata;
                        req   <= 1'b0;
                        state <= INI_RELEASE;
                    end
                end
                INI_RELEASE: begin
                    if (!ack_seen) begin
                        rsp_valid <= 1'b1;
                        state     <= INI_IDLE;
                    end
                end
                default: state <= INI_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == INI_IDLE);
    assign bus_cmd   = cmd_q;
    assign rsp_rdata = rdata_q;

    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> $past(ack_seen)) else $error("req fell without ack seen"); // R4

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid) else $error("rsp_valid longer than one cycle"); // R10

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        req |-> !cmd_ready) else $error("ready while request high"); // R9
endmodule

// File: rtl/hs_responder.sv
module hs_responder
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_line,
    input  hs_cmd_t  bus_cmd,
    output logic     ack,
    output hs_data_t bus_rdata
);
    rsp_state_t state;
    hs_data_t   store [HS_DEPTH];
    hs_data_t   rdata_q;
    logic       req_seen;

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_line),
        .q   (req_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RSP_WAIT;
            ack     <= 1'b0;
            rdata_q <= '0;
            for (int i = 0; i < HS_DEPTH; i++) store[i] <= '0;
        end else begin
            case (state)
                RSP_WAIT: begin
                    if (req_seen) begin
                        if (bus_cmd.write) store[bus_cmd.addr] <= bus_cmd.wdata;
                        else               rdata_q <= store[bus_cmd.addr];
                        ack   <= 1'b1;
                        state <= RSP_HOLD;
                    end
                end
                RSP_HOLD: begin
                    if (!req_seen) begin
                        ack   <= 1'b0;
                        state <= RSP_WAIT;
                    end
                end
                default: state <= RSP_WAIT;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    AST_ACK_RISE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_line)) else $error("ack rose without request"); // R3

    AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_line)) else $error("ack fell while request high"); // R5

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(bus_rdata)) else $error("read word moved under ack"); // R8
endmodule

// File: rtl/hs_link.sv
module hs_link
    import hs_pkg::*;
#(
    parameter int SETTLE_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [HS_ADDR_W-1:0] cmd_addr,
    input  logic [HS_DATA_W-1:0] cmd_wdata,
    output logic                 cmd_ready,
    output logic                 rsp_valid,
    output logic [HS_DATA_W-1:0] rsp_rdata,
    output logic                 bus_req,
    output logic                 bus_ack,
    output logic [HS_ADDR_W-1:0] bus_addr,
    output logic                 bus_write
);
    hs_cmd_t  cmd_in;
    hs_cmd_t  bus_cmd;
    hs_data_t bus_rdata;

    assign cmd_in = '{write: cmd_write, addr: cmd_addr, wdata: cmd_wdata};

    hs_initiator #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ini (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .req       (bus_req),
        .ack_line  (bus_ack),
        .bus_cmd   (bus_cmd),
        .bus_rdata (bus_rdata)
    );

    hs_responder #(.SYNC_STAGES(SYNC_STAGES)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .req_line  (bus_req),
        .bus_cmd   (bus_cmd),
        .ack       (bus_ack),
        .bus_rdata (bus_rdata)
    );

    assign bus_addr  = bus_cmd.addr;
    assign bus_write = bus_cmd.write;

    AST_HS_ORDER: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> hs_step_ok($past(bus_req), $past(bus_ack), bus_req, bus_ack))
        else $error("illegal req/ack step"); // R6

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_req) || $past(bus_ack)) |-> ($stable(bus_addr) && $stable(bus_write)))
        else $error("address moved during handshake"); // R11
endmodule

// File: tb/hs_link_tb.sv
`timescale 1ns/1ps
module hs_link_tb;
    localparam int SETTLE = 2;
    localparam int LAT    = SETTLE + 13; // falling edges from offer to rsp_valid
    localparam int REQ_AT = SETTLE + 1;  // falling edges from offer to first req high

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_write;
    logic [3:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       cmd_ready, rsp_valid, bus_req, bus_ack, bus_write;
    logic [7:0] rsp_rdata;
    logic [3:0] bus_addr;

    int checks = 0;
    int fails  = 0;
    int hs_bad = 0;
    logic [7:0] ref_mem [16];

    always #4 clk = ~clk;

    hs_link #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_req(bus_req),
        .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_write(bus_write)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 4'h3, 8'hA5}, '{1'b1, 4'hF, 8'h5A}, '{1'b1, 4'h0, 8'hFF},
        '{1'b0, 4'h3, 8'h00}, '{1'b0, 4'hF, 8'h00}, '{1'b0, 4'h9, 8'h00},
        '{1'b1, 4'h3, 8'h3C}, '{1'b0, 4'h3, 8'h00}, '{1'b0, 4'h0, 8'h00},
        '{1'b1, 4'h7, 8'h81}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R6: legal req/ack steps, watched every falling edge
    logic pr = 1'b0, pa = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!((({pr, pa} == {bus_req, bus_ack})) ||
                  ({pr, pa} == 2'b00 && {bus_req, bus_ack} == 2'b10) ||
                  ({pr, pa} == 2'b10 && {bus_req, bus_ack} == 2'b11) ||
                  ({pr, pa} == 2'b11 && {bus_req, bus_ack} == 2'b01) ||
                  ({pr, pa} == 2'b01 && {bus_req, bus_ack} == 2'b00)))
                hs_bad++;
            // R11: address and direction frozen during handshake
            if ((pr || pa) && (bus_addr !== addr_prev || bus_write !== wr_prev)) hs_bad++;
        end
        pr <= bus_req;
        pa <= bus_ack;
        addr_prev <= bus_addr;
        wr_prev   <= bus_write;
    end
    logic [3:0] addr_prev = 4'h0;
    logic       wr_prev   = 1'b0;

    task automatic run_txn(input logic wr, input logic [3:0] a, input logic [7:0] d,
                           input bit inject, output logic [7:0] rd,
                           output int lat, output int req_at, output logic busy_ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        lat = 0; req_at = 0; rd = 8'h00; busy_ok = 1'b1;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (n == 1) cmd_valid = 1'b0;
            if (n >= 1 && n < LAT && cmd_ready) busy_ok = 1'b0;
            if (n == 2 && (bus_addr !== a || bus_write !== wr)) busy_ok = 1'b0;
            if (inject && n == 3) begin
                cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a ^ 4'h1; cmd_wdata = 8'hEE;
            end
            if (inject && n == 6) cmd_valid = 1'b0;
            if (bus_req && req_at == 0) req_at = n;
            if (rsp_valid) begin
                lat = n;
                rd  = rsp_rdata;
                break;
            end
        end
        @(negedge clk);
        if (rsp_valid) busy_ok = 1'b0; // pulse must be one cycle
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        int lat, req_at;
        logic ok;
        rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        for (int i = 0; i < 16; i++) ref_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(bus_req == 1'b0 && bus_ack == 1'b0, "R1 lines", {bus_req, bus_ack}, 0);
        check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready", {cmd_ready, rsp_valid}, 2);
        rst = 1'b0;

        // R1 store cleared: read an untouched word
        run_txn(1'b0, 4'hC, 8'h00, 1'b0, rd, lat, req_at, ok);
        check(rd == 8'h00, "R1 store zero", rd, 0);

        // Vector table
        for (int v = 0; v < 10; v++) begin
            run_txn(VECS[v].wr, VECS[v].addr, VECS[v].data, 1'b0, rd, lat, req_at, ok);
            check(req_at == REQ_AT, "R2 settle", req_at, REQ_AT);
            check(lat == LAT, "R10 latency", lat, LAT);
            check(ok, "R9 R10 ready/pulse/bus", ok, 1);
            if (VECS[v].wr) ref_mem[VECS[v].addr] = VECS[v].data;
            else check(rd == ref_mem[VECS[v].addr], "R7 R8 read data", rd, ref_mem[VECS[v].addr]);
        end

        // R9: command offered while busy is ignored
        run_txn(1'b1, 4'h4, 8'h42, 1'b1, rd, lat, req_at, ok);
        ref_mem[4] = 8'h42;
        check(ok, "R9 busy ready", ok, 1);
        run_txn(1'b0, 4'h5, 8'h00, 1'b0, rd, lat, req_at, ok);
        check(rd == ref_mem[5], "R9 ignored write", rd, ref_mem[5]);
        run_txn(1'b0, 4'h4, 8'h00, 1'b0, rd, lat, req_at, ok);
        check(rd == 8'h42, "R7 write then read", rd, 8'h42);

        // Back-to-back reads of every location
        for (int a = 0; a < 16; a++) begin
            run_txn(1'b0, 4'(a), 8'h00, 1'b0, rd, lat, req_at, ok);
            check(rd == ref_mem[a], "R8 sweep", rd, ref_mem[a]);
        end

        // R3 R4 R5 R6 R11 via monitor
        check(hs_bad == 0, "R6 R3 R4 R5 R11 handshake order", hs_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule